// File: doc/BRIEF.md
# Address Translation Front End with Fault Syndromes

This block sits in front of a segment lookup buffer and a hashed page-table walker. For every memory access it decides whether translation applies at all, given the access type and two separate relocate enables: one for instruction fetches and one for loads and stores. An untranslated access completes at once with a real address formed from the effective address. A translated access first queries the segment buffer, then, if the segment exists and permits the access, the page walker. Both neighbours are driven through request/response handshakes.

The result of every access is a one-cycle completion pulse carrying either a valid translation (real address, page address and read/write/execute permissions) or a fault record. The fault record gives an exception class and a fixed error code. Data-side faults also load a held faulting-address register and, where a syndrome applies, a held data-syndrome register. Only one access is in flight at a time. A new request is taken only while the block is idle.

Top module: `xlate_fault_frontend`

## Requirements
- R1: A fetch (req_kind 2) with instr_reloc low is untranslated whatever data_reloc is: done rises in the cycle after acceptance, seg_req and walk_req stay low, raddr is req_addr with its top 4 bits cleared, and perm is 3'b111 (bit 0 read, bit 1 write, bit 2 execute).
- R2: A load (req_kind 0) or store (req_kind 1) with data_reloc low is untranslated whatever instr_reloc is, with the same timing, address and permissions as R1.
- R3: A translated access holds seg_req high from the cycle after acceptance through the cycle in which seg_resp_valid is sampled. It then, if needed, holds walk_req high from the next cycle through the cycle in which walk_resp_valid is sampled. seg_req and walk_req are never high together.
- R4: A fetch whose segment response has seg_noexec set finishes without any walk request, with exc_kind 1 (instruction storage) and err_code 0x10000000. For loads and stores seg_noexec has no effect.
- R5: A fetch walk status of 1 (no translation) gives exc_kind 1 with err_code 0x40000000. Status 2 (protection) gives exc_kind 1 with err_code 0x08000000. Status 3 is treated as status 1 for every access type.
- R6: A segment miss (seg_hit low) on a fetch gives exc_kind 3 with err_code 0. On a load or store it gives exc_kind 4, loads dar with the effective address and leaves dsisr unchanged.
- R7: A data walk fault gives exc_kind 2 with err_code 0 and loads dar with the effective address. dsisr becomes 0x40000000 for no translation and 0x08000000 for protection, with 0x02000000 added for a store.
- R8: Walk status 0 gives ok high with raddr = walk_raddr and perm = walk_perm. On any success page_addr equals raddr with its 12 low bits cleared. On a fault raddr, page_addr and perm are zero.
- R9: done is high for exactly one cycle per access, and while it is high exactly one of ok and a non-zero exc_kind holds.
- R10: After reset req_ready is high, done, seg_req and walk_req are low, and dar and dsisr are zero.
- R11: dar and dsisr change only when a data fault completes as described in R6 and R7. Instruction faults and successes leave them as they were.
- R12: req_ready is low from acceptance through the done cycle, and a req_valid presented then is ignored: the access in flight completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | High when idle and a request is taken |
| req_addr | input | AW | Effective address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| instr_reloc | input | 1 | Translate fetches when high |
| data_reloc | input | 1 | Translate loads and stores when high |
| seg_req | output | 1 | Segment lookup request |
| seg_addr | output | AW | Address for the segment lookup |
| seg_resp_valid | input | 1 | Segment response present |
| seg_hit | input | 1 | Segment found |
| seg_noexec | input | 1 | Segment forbids execution |
| walk_req | output | 1 | Page walk request |
| walk_addr | output | AW | Address for the walk |
| walk_kind | output | 2 | Access type forwarded to the walker |
| walk_resp_valid | input | 1 | Walk response present |
| walk_status | input | 2 | 0 ok, 1 no translation, 2 protection, 3 treated as 1 |
| walk_raddr | input | AW | Translated real address |
| walk_perm | input | 3 | Permissions of the translated page |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Completion carries a translation |
| raddr | output | AW | Real address |
| page_addr | output | AW | Real address with page offset cleared |
| perm | output | 3 | Granted permissions |
| exc_kind | output | 3 | 0 none, 1 instr storage, 2 data storage, 3 instr segment, 4 data segment |
| err_code | output | 32 | Instruction-side error code |
| dar | output | AW | Held data faulting address |
| dsisr | output | 32 | Held data syndrome |

## Verification
An untranslated access completes with done exactly one cycle after the accepting edge. For a translated one, done follows the edge that samples the final response by one cycle. seg_req holds for the whole segment wait and walk_req starts on the cycle after the segment response. dar and dsisr take their new values in the same cycle that done rises. The bench steps a behavioural model through each access one falling edge at a time, with segment and walk latencies of its choosing. At every falling edge it compares the request lines, req_ready and done with the phase the model predicts, and it compares the result fields and both held registers only in the predicted done cycle.

// File: rtl/xfe_pkg.sv
// Package: shared encodings for the translation front end.
// Assumes: access, walk status and exception codes are fixed by the
// block's neighbours and by software, so the values below must not move.
package xfe_pkg;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        WST_OK      = 2'd0,
        WST_NOTRANS = 2'd1,
        WST_PROT    = 2'd2
    } wst_e;

    typedef enum logic [2:0] {
        EXC_NONE  = 3'd0,
        EXC_ISTOR = 3'd1,
        EXC_DSTOR = 3'd2,
        EXC_ISEG  = 3'd3,
        EXC_DSEG  = 3'd4
    } exc_e;

    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_SEGMISS = 3'd1,
        CAUSE_NOEXEC  = 3'd2,
        CAUSE_NOTRANS = 3'd3,
        CAUSE_PROT    = 3'd4
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEG  = 2'd1,
        ST_WALK = 2'd2,
        ST_DONE = 2'd3
    } state_e;

    localparam int CODE_W = 32;
    localparam int PERM_W = 3;

    localparam logic [PERM_W-1:0] PERM_ALL     = 3'b111;
    localparam logic [CODE_W-1:0] CODE_NOTRANS = 32'h4000_0000;
    localparam logic [CODE_W-1:0] CODE_PROT    = 32'h0800_0000;
    localparam logic [CODE_W-1:0] CODE_NOEXEC  = 32'h1000_0000;
    localparam logic [CODE_W-1:0] CODE_STORE   = 32'h0200_0000;

endpackage

// File: rtl/xfe_mode_sel.sv
// Module: decides per access whether translation is bypassed and forms
// the untranslated real address.
// Assumes: fetches follow only the instruction enable, loads and stores
// only the data enable; the top CLR_BITS of the address are dropped.
module xfe_mode_sel
    import xfe_pkg::*;
#(
    parameter int AW       = 64,
    parameter int CLR_BITS = 4
) (
    input  acc_e          kind,
    input  logic          instr_reloc,
    input  logic          data_reloc,
    input  logic [AW-1:0] addr,
    output logic          bypass,
    output logic [AW-1:0] real_addr
);
    localparam logic [AW-1:0] KEEP_MASK = {AW{1'b1}} >> CLR_BITS;

    // Choose the relocate enable that governs this access type.
    always_comb begin
        if (kind == ACC_FETCH) begin
            bypass = !instr_reloc;
        end else begin
            bypass = !data_reloc;
        end
    end

    // Untranslated address keeps only the low AW-CLR_BITS bits.
    assign real_addr = addr & KEEP_MASK;
endmodule

// File: rtl/xfe_fault_enc.sv
// Module: maps a failure cause and access type to an exception class,
// an instruction-side error code and a data-side syndrome.
// Assumes: CAUSE_NOEXEC is only raised for fetches by the caller.
module xfe_fault_enc
    import xfe_pkg::*;
(
    input  acc_e              kind,
    input  cause_e            cause,
    output exc_e              exc,
    output logic [CODE_W-1:0] err_code,
    output logic [CODE_W-1:0] syndrome,
    output logic              cap_addr,
    output logic              upd_syn
);
    logic is_fetch;
    logic is_store;

    assign is_fetch = (kind == ACC_FETCH);
    assign is_store = (kind == ACC_STORE);

    // Select class and codes; data faults add the store flag to the syndrome.
    always_comb begin
        exc      = EXC_NONE;
        err_code = '0;
        syndrome = '0;
        cap_addr = 1'b0;
        upd_syn  = 1'b0;
        unique case (cause)
            CAUSE_SEGMISS: begin
                if (is_fetch) begin
                    exc = EXC_ISEG;
                end else begin
                    exc      = EXC_DSEG;
                    cap_addr = 1'b1;
                end
            end
            CAUSE_NOEXEC: begin
                exc      = EXC_ISTOR;
                err_code = CODE_NOEXEC;
            end
            CAUSE_NOTRANS, CAUSE_PROT: begin
                if (is_fetch) begin
                    exc      = EXC_ISTOR;
                    err_code = (cause == CAUSE_PROT) ? CODE_PROT : CODE_NOTRANS;
                end else begin
                    exc      = EXC_DSTOR;
                    cap_addr = 1'b1;
                    upd_syn  = 1'b1;
                    syndrome = ((cause == CAUSE_PROT) ? CODE_PROT : CODE_NOTRANS)
                             | (is_store ? CODE_STORE : '0);
                end
            end
            default: begin
                exc = EXC_NONE;
            end
        endcase
    end
endmodule

// File: rtl/xfe_page_mask.sv
// Module: clears the page offset of a real address.
// Assumes: page size is 2**PAGE_SHIFT bytes for the reported page.
module xfe_page_mask #(
    parameter int AW         = 64,
    parameter int PAGE_SHIFT = 12
) (
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] page
);
    localparam logic [AW-1:0] PAGE_MASK = {AW{1'b1}} << PAGE_SHIFT;

    // Drop the offset bits within the page.
    assign page = addr & PAGE_MASK;
endmodule

// File: rtl/xlate_fault_frontend.sv
// Module: top control for address translation. Accepts one access at a
// time, bypasses or runs segment lookup then page walk, and reports a
// one-cycle done with a translation or a fault record.
// Assumes: neighbours answer each request eventually; responses are
// only looked at in the matching wait state.
module xlate_fault_frontend
    import xfe_pkg::*;
#(
    parameter int AW         = 64,
    parameter int PAGE_SHIFT = 12,
    parameter int CLR_BITS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AW-1:0]     req_addr,
    input  logic [1:0]        req_kind,
    input  logic              instr_reloc,
    input  logic              data_reloc,
    output logic              seg_req,
    output logic [AW-1:0]     seg_addr,
    input  logic              seg_resp_valid,
    input  logic              seg_hit,
    input  logic              seg_noexec,
    output logic              walk_req,
    output logic [AW-1:0]     walk_addr,
    output logic [1:0]        walk_kind,
    input  logic              walk_resp_valid,
    input  logic [1:0]        walk_status,
    input  logic [AW-1:0]     walk_raddr,
    input  logic [2:0]        walk_perm,
    output logic              done,
    output logic              ok,
    output logic [AW-1:0]     raddr,
    output logic [AW-1:0]     page_addr,
    output logic [2:0]        perm,
    output logic [2:0]        exc_kind,
    output logic [31:0]       err_code,
    output logic [AW-1:0]     dar,
    output logic [31:0]       dsisr
);
    state_e            st_q;
    logic [AW-1:0]     addr_q;
    acc_e              kind_q;
    logic              ok_q;
    logic [AW-1:0]     raddr_q;
    logic [PERM_W-1:0] perm_q;
    exc_e              exc_q;
    logic [CODE_W-1:0] err_q;
    logic [AW-1:0]     dar_q;
    logic [CODE_W-1:0] dsisr_q;

    acc_e              req_kind_e;
    logic              bypass;
    logic [AW-1:0]     bypass_addr;

    cause_e            cause_d;
    logic              finish_d;
    logic              to_walk_d;
    exc_e              enc_exc;
    logic [CODE_W-1:0] enc_err;
    logic [CODE_W-1:0] enc_syn;
    logic              enc_cap;
    logic              enc_upd;

    assign req_kind_e = acc_e'(req_kind);

    xfe_mode_sel #(
        .AW       (AW),
        .CLR_BITS (CLR_BITS)
    ) u_mode (
        .kind        (req_kind_e),
        .instr_reloc (instr_reloc),
        .data_reloc  (data_reloc),
        .addr        (req_addr),
        .bypass      (bypass),
        .real_addr   (bypass_addr)
    );

    xfe_fault_enc u_enc (
        .kind     (kind_q),
        .cause    (cause_d),
        .exc      (enc_exc),
        .err_code (enc_err),
        .syndrome (enc_syn),
        .cap_addr (enc_cap),
        .upd_syn  (enc_upd)
    );

    xfe_page_mask #(
        .AW         (AW),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_page (
        .addr (raddr_q),
        .page (page_addr)
    );

    // Classify the response seen in the current wait state.
    always_comb begin
        cause_d   = CAUSE_NONE;
        finish_d  = 1'b0;
        to_walk_d = 1'b0;
        unique case (st_q)
            ST_SEG: begin
                if (seg_resp_valid) begin
                    if (!seg_hit) begin
                        cause_d  = CAUSE_SEGMISS;
                        finish_d = 1'b1;
                    end else if (kind_q == ACC_FETCH && seg_noexec) begin
                        cause_d  = CAUSE_NOEXEC;
                        finish_d = 1'b1;
                    end else begin
                        to_walk_d = 1'b1;
                    end
                end
            end
            ST_WALK: begin
                if (walk_resp_valid) begin
                    finish_d = 1'b1;
                    unique case (walk_status)
                        WST_OK:   cause_d = CAUSE_NONE;
                        WST_PROT: cause_d = CAUSE_PROT;
                        default:  cause_d = CAUSE_NOTRANS;
                    endcase
                end
            end
            default: begin
                cause_d = CAUSE_NONE;
            end
        endcase
    end

    // Sequence the access and register its result at entry to DONE.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            addr_q  <= '0;
            kind_q  <= ACC_LOAD;
            ok_q    <= 1'b0;
            raddr_q <= '0;
            perm_q  <= '0;
            exc_q   <= EXC_NONE;
            err_q   <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q <= req_addr;
                        kind_q <= req_kind_e;
                        if (bypass) begin
                            st_q    <= ST_DONE;
                            ok_q    <= 1'b1;
                            raddr_q <= bypass_addr;
                            perm_q  <= PERM_ALL;
                            exc_q   <= EXC_NONE;
                            err_q   <= '0;
                        end else begin
                            st_q <= ST_SEG;
                        end
                    end
                end
                ST_SEG, ST_WALK: begin
                    if (to_walk_d) begin
                        st_q <= ST_WALK;
                    end else if (finish_d) begin
                        st_q <= ST_DONE;
                        if (cause_d == CAUSE_NONE) begin
                            ok_q    <= 1'b1;
                            raddr_q <= walk_raddr;
                            perm_q  <= walk_perm;
                            exc_q   <= EXC_NONE;
                            err_q   <= '0;
                        end else begin
                            ok_q    <= 1'b0;
                            raddr_q <= '0;
                            perm_q  <= '0;
                            exc_q   <= enc_exc;
                            err_q   <= enc_err;
                        end
                    end
                end
                default: begin
                    st_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Held data-fault registers, loaded only by completing data faults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dar_q   <= '0;
            dsisr_q <= '0;
        end else if (finish_d && cause_d != CAUSE_NONE) begin
            if (enc_cap) begin
                dar_q <= addr_q;
            end
            if (enc_upd) begin
                dsisr_q <= enc_syn;
            end
        end
    end

    assign req_ready = (st_q == ST_IDLE);
    assign seg_req   = (st_q == ST_SEG);
    assign walk_req  = (st_q == ST_WALK);
    assign seg_addr  = addr_q;
    assign walk_addr = addr_q;
    assign walk_kind = kind_q;
    assign done      = (st_q == ST_DONE);
    assign ok        = done && ok_q;
    assign raddr     = done ? raddr_q : '0;
    assign perm      = done ? perm_q : '0;
    assign exc_kind  = done ? exc_q : EXC_NONE;
    assign err_code  = done ? err_q : '0;
    assign dar       = dar_q;
    assign dsisr     = dsisr_q;
endmodule

// File: rtl/xfe_chk.sv
// Module: temporal checks on the translation front end ports, bound to
// every instance of the top module.
// Assumes: reset is held low before the first rising edge.
module xfe_chk #(
    parameter int AW         = 64,
    parameter int PAGE_SHIFT = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          seg_req,
    input logic          seg_resp_valid,
    input logic          walk_req,
    input logic          done,
    input logic          ok,
    input logic [AW-1:0] raddr,
    input logic [AW-1:0] page_addr,
    input logic [2:0]    exc_kind,
    input logic [31:0]   err_code,
    input logic [AW-1:0] dar,
    input logic [31:0]   dsisr
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ok == (exc_kind == 3'd0)));

    // R3
    req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(seg_req && walk_req));

    // R3
    seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_req && !seg_resp_valid) |=> seg_req);

    // R3
    walk_after_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(walk_req) |-> $past(seg_req && seg_resp_valid));

    // R8
    page_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ok) |-> (page_addr[PAGE_SHIFT-1:0] == '0
                          && page_addr[AW-1:PAGE_SHIFT] == raddr[AW-1:PAGE_SHIFT]));

    // R11
    dar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dar) |-> (done && (exc_kind == 3'd2 || exc_kind == 3'd4)));

    // R11
    dsisr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dsisr) |-> (done && exc_kind == 3'd2));

    // R12
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_req || walk_req || done) |-> !req_ready);

    // R7
    data_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && exc_kind == 3'd2) |-> (err_code == 32'd0));
endmodule

bind xlate_fault_frontend xfe_chk #(
    .AW         (AW),
    .PAGE_SHIFT (PAGE_SHIFT)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_ready      (req_ready),
    .seg_req        (seg_req),
    .seg_resp_valid (seg_resp_valid),
    .walk_req       (walk_req),
    .done           (done),
    .ok             (ok),
    .raddr          (raddr),
    .page_addr      (page_addr),
    .exc_kind       (exc_kind),
    .err_code       (err_code),
    .dar            (dar),
    .dsisr          (dsisr)
);

// File: tb/xlate_fault_frontend_tb.sv
`timescale 1ns/1ps
module xlate_fault_frontend_tb;
    localparam int AW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_kind = 2'd0;
    logic          instr_reloc = 1'b0;
    logic          data_reloc = 1'b0;
    logic          seg_req;
    logic [AW-1:0] seg_addr;
    logic          seg_resp_valid = 1'b0;
    logic          seg_hit = 1'b0;
    logic          seg_noexec = 1'b0;
    logic          walk_req;
    logic [AW-1:0] walk_addr;
    logic [1:0]    walk_kind;
    logic          walk_resp_valid = 1'b0;
    logic [1:0]    walk_status = 2'd0;
    logic [AW-1:0] walk_raddr = '0;
    logic [2:0]    walk_perm = '0;
    logic          done;
    logic          ok;
    logic [AW-1:0] raddr;
    logic [AW-1:0] page_addr;
    logic [2:0]    perm;
    logic [2:0]    exc_kind;
    logic [31:0]   err_code;
    logic [AW-1:0] dar;
    logic [31:0]   dsisr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // reference model's held data-fault registers
    logic [AW-1:0] m_dar = '0;
    logic [31:0]   m_dsisr = '0;

    xlate_fault_frontend u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_kind(req_kind), .instr_reloc(instr_reloc),
        .data_reloc(data_reloc), .seg_req(seg_req), .seg_addr(seg_addr),
        .seg_resp_valid(seg_resp_valid), .seg_hit(seg_hit), .seg_noexec(seg_noexec),
        .walk_req(walk_req), .walk_addr(walk_addr), .walk_kind(walk_kind),
        .walk_resp_valid(walk_resp_valid), .walk_status(walk_status),
        .walk_raddr(walk_raddr), .walk_perm(walk_perm), .done(done), .ok(ok),
        .raddr(raddr), .page_addr(page_addr), .perm(perm), .exc_kind(exc_kind),
        .err_code(err_code), .dar(dar), .dsisr(dsisr)
    );

    always #2.5 clk = ~clk;

    // watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 100000)", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One access stepped through the behavioural phase model:
    // phase 1 segment wait, 2 walk wait, 3 done.
    task automatic run_txn(input string tag, input logic [AW-1:0] a,
                           input logic [1:0] k, input bit ir, input bit dr,
                           input int slat, input bit hit, input bit nx,
                           input int wlat, input logic [1:0] wst,
                           input logic [AW-1:0] wra, input logic [2:0] wp,
                           input bit poke);
        bit            byp;
        bit            isf;
        bit            iss;
        bit            prot;
        logic          e_ok;
        logic [2:0]    e_exc;
        logic [31:0]   e_err;
        logic [AW-1:0] e_ra;
        logic [2:0]    e_pm;
        int            ph;
        int            ph_n;
        int            cnt;
        byp  = (k == 2'd2) ? !ir : !dr;
        isf  = (k == 2'd2);
        iss  = (k == 2'd1);
        prot = (wst == 2'd2);
        e_ok = 1'b0; e_exc = 3'd0; e_err = '0; e_ra = '0; e_pm = '0;
        if (byp) begin
            e_ok = 1'b1; e_ra = a & 64'h0FFF_FFFF_FFFF_FFFF; e_pm = 3'b111;
        end else if (!hit) begin
            if (isf) e_exc = 3'd3;
            else begin e_exc = 3'd4; m_dar = a; end
        end else if (isf && nx) begin
            e_exc = 3'd1; e_err = 32'h1000_0000;
        end else if (wst == 2'd0) begin
            e_ok = 1'b1; e_ra = wra; e_pm = wp;
        end else if (isf) begin
            e_exc = 3'd1; e_err = prot ? 32'h0800_0000 : 32'h4000_0000;
        end else begin
            e_exc = 3'd2; m_dar = a;
            m_dsisr = (prot ? 32'h0800_0000 : 32'h4000_0000) | (iss ? 32'h0200_0000 : 32'h0);
        end

        @(negedge clk);
        chk("R12", "ready before request", {63'd0, req_ready}, 64'd1);
        req_valid = 1'b1; req_addr = a; req_kind = k;
        instr_reloc = ir; data_reloc = dr;
        @(negedge clk);
        req_valid = poke;
        if (poke) req_addr = ~a;
        ph = byp ? 3 : 1;
        cnt = 1;
        for (int g = 0; g < 64; g++) begin
            chk("R3", "seg_req", {63'd0, seg_req}, {63'd0, ph == 1});
            chk("R3", "walk_req", {63'd0, walk_req}, {63'd0, ph == 2});
            chk("R9", "done", {63'd0, done}, {63'd0, ph == 3});
            chk("R12", "ready while busy", {63'd0, req_ready}, 64'd0);
            if (ph == 3) begin
                req_valid = 1'b0;
                chk(tag, "ok", {63'd0, ok}, {63'd0, e_ok});
                chk(tag, "exc_kind", {61'd0, exc_kind}, {61'd0, e_exc});
                chk(tag, "err_code", {32'd0, err_code}, {32'd0, e_err});
                chk(tag, "raddr", raddr, e_ra);
                chk("R8", "page_addr", page_addr, e_ra & ~64'hFFF);
                chk(tag, "perm", {61'd0, perm}, {61'd0, e_pm});
                chk("R11", "dar", dar, m_dar);
                chk("R11", "dsisr", {32'd0, dsisr}, {32'd0, m_dsisr});
                break;
            end
            ph_n = ph;
            if (ph == 1) begin
                if (cnt == slat) begin
                    seg_resp_valid = 1'b1; seg_hit = hit; seg_noexec = nx;
                    ph_n = (!hit || (isf && nx)) ? 3 : 2;
                    cnt = 1;
                end else cnt++;
            end else if (ph == 2) begin
                if (cnt == wlat) begin
                    walk_resp_valid = 1'b1; walk_status = wst;
                    walk_raddr = wra; walk_perm = wp;
                    ph_n = 3;
                    cnt = 1;
                end else cnt++;
            end
            @(negedge clk);
            seg_resp_valid = 1'b0;
            walk_resp_valid = 1'b0;
            seg_hit = 1'b0; seg_noexec = 1'b0;
            walk_raddr = '0; walk_perm = '0; walk_status = 2'd0;
            ph = ph_n;
        end
        @(negedge clk);
        chk("R9", "done after pulse", {63'd0, done}, 64'd0);
        chk("R12", "ready after done", {63'd0, req_ready}, 64'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", "ready in reset", {63'd0, req_ready}, 64'd1);
        chk("R10", "done in reset", {63'd0, done}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "ready after reset", {63'd0, req_ready}, 64'd1);
        chk("R10", "seg_req after reset", {63'd0, seg_req}, 64'd0);
        chk("R10", "walk_req after reset", {63'd0, walk_req}, 64'd0);
        chk("R10", "dar after reset", dar, 64'd0);
        chk("R10", "dsisr after reset", {32'd0, dsisr}, 64'd0);

        // R1: fetch bypass, data relocate on and off
        run_txn("R1", 64'hF234_5678_9ABC_DEF0, 2'd2, 1'b0, 1'b1, 1, 1, 0, 1, 0, '0, '0, 0);
        run_txn("R1", 64'hA000_0000_0000_1FFF, 2'd2, 1'b0, 1'b0, 1, 1, 0, 1, 0, '0, '0, 0);
        // R2: load and store bypass with instr relocate on
        run_txn("R2", 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 1'b1, 1'b0, 1, 1, 0, 1, 0, '0, '0, 0);
        run_txn("R2", 64'h7123_0000_4444_5555, 2'd1, 1'b1, 1'b0, 1, 1, 0, 1, 0, '0, '0, 0);
        // R8: translated successes, several latencies
        run_txn("R8", 64'h0000_1234_0000_0ABC, 2'd2, 1'b1, 1'b0, 1, 1, 0, 1, 0,
                64'h0000_0008_8000_3ABC, 3'b101, 0);
        run_txn("R8", 64'h0000_5555_0000_0123, 2'd0, 1'b0, 1'b1, 3, 1, 0, 2, 0,
                64'h0000_0000_CAFE_E123, 3'b011, 0);
        // R4: fetch blocked by segment no-execute; load ignores it
        run_txn("R4", 64'h0000_0000_0040_0000, 2'd2, 1'b1, 1'b1, 2, 1, 1, 1, 0, '0, '0, 0);
        run_txn("R4", 64'h0000_0000_0040_0010, 2'd0, 1'b1, 1'b1, 1, 1, 1, 1, 0,
                64'h0000_0000_0001_2010, 3'b001, 0);
        // R5: fetch walk faults, status 3 as no translation
        run_txn("R5", 64'h0000_0000_1000_0000, 2'd2, 1'b1, 1'b0, 1, 1, 0, 2, 1, '0, '0, 0);
        run_txn("R5", 64'h0000_0000_1000_1000, 2'd2, 1'b1, 1'b0, 1, 1, 0, 1, 2, '0, '0, 0);
        run_txn("R5", 64'h0000_0000_1000_2000, 2'd2, 1'b1, 1'b0, 2, 1, 0, 3, 3, '0, '0, 0);
        // R7: data walk faults for load and store
        run_txn("R7", 64'h0000_0000_2000_0008, 2'd0, 1'b0, 1'b1, 1, 1, 0, 1, 1, '0, '0, 0);
        run_txn("R7", 64'h0000_0000_2000_0010, 2'd1, 1'b0, 1'b1, 1, 1, 0, 1, 1, '0, '0, 0);
        run_txn("R7", 64'h0000_0000_2000_0018, 2'd0, 1'b0, 1'b1, 2, 1, 0, 1, 2, '0, '0, 0);
        run_txn("R7", 64'h0000_0000_2000_0020, 2'd1, 1'b0, 1'b1, 1, 1, 0, 2, 2, '0, '0, 0);
        run_txn("R7", 64'h0000_0000_2000_0028, 2'd1, 1'b0, 1'b1, 1, 1, 0, 1, 3, '0, '0, 0);
        // R11: instruction fault and success leave dar and dsisr alone
        run_txn("R11", 64'h0000_0000_3000_0000, 2'd2, 1'b1, 1'b0, 1, 1, 0, 1, 2, '0, '0, 0);
        // R6: segment misses on fetch, load and store
        run_txn("R6", 64'h0000_0000_4000_0000, 2'd2, 1'b1, 1'b1, 1, 0, 0, 1, 0, '0, '0, 0);
        run_txn("R6", 64'h0000_0000_4000_0100, 2'd0, 1'b1, 1'b1, 3, 0, 0, 1, 0, '0, '0, 0);
        run_txn("R6", 64'h0000_0000_4000_0200, 2'd1, 1'b0, 1'b1, 1, 0, 0, 1, 0, '0, '0, 0);
        // R12: request held high during a busy access is ignored
        run_txn("R12", 64'h0000_0000_5000_0ABC, 2'd0, 1'b0, 1'b1, 2, 1, 0, 2, 0,
                64'h0000_0000_0077_7ABC, 3'b111, 1);
        run_txn("R12", 64'h0000_0000_5000_1000, 2'd1, 1'b0, 1'b1, 1, 1, 0, 3, 2, '0, '0, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule